// File: doc/BRIEF.md
# Write-Through Serial EEPROM Parameter Port

This block is the serial master that sits between a controller's non-volatile parameter space and an external serial EEPROM. It drives four pins: a serial clock, a data line out, a data line in and an active-low select. Right after reset it reads the status register once, which opens the parameter map. It then reads a fixed run of bytes from the bottom of the EEPROM and presents each byte on a load strobe so that local registers can be filled.

A host write request is not accepted while this load runs. Once the load is over, each write goes through the same fixed sequence. The block sends a write-enable command, then the write command with the address and the data, then reads the status register until the busy bit clears, and finally reads the byte back. Only after that read-back does it acknowledge the host, with an error flag that is set when the byte read back differs from the byte written. All serial timing comes from cycle counters on the system clock.

The sequencer states are `SQ_BOOT_STAT` (status read at startup), `SQ_BOOT_LOAD` (one read per configuration byte), `SQ_READY` (waiting for a request), `SQ_WREN`, `SQ_WRITE`, `SQ_POLL` (status re-read while busy), `SQ_VERIFY` (read-back) and `SQ_ACK` (one-cycle acknowledge). The transitions are:
- BOOT_STAT goes to BOOT_LOAD.
- BOOT_LOAD goes to READY after the last byte.
- READY goes to WREN on a request.
- WREN goes to WRITE, and WRITE goes to POLL.
- POLL stays in POLL while busy and goes to VERIFY when the busy bit is clear.
- VERIFY goes to ACK, and ACK goes back to READY.

The frame engine has its own states: `FR_IDLE`, `FR_SETUP`, `FR_HIGH`, `FR_LOW`, `FR_HOLD` and `FR_GAP`.

Top module: `nvm_spi_writethru`

## Requirements
- R1: While reset is held, `spi_cs_n`=1, `spi_sck`=0, `cfg_ready`=0 and `wr_ack`=0.
- R2: `spi_sck` idles low and is high only while `spi_cs_n` is low. `spi_mosi` changes only on a rising `spi_sck`. The block captures `spi_miso` at the falling `spi_sck`.
- R3: Each serial clock is high for HALF (32) system cycles and low for HALF (32) system cycles inside a frame, giving 64 cycles per bit.
- R4: The first rising `spi_sck` comes CS_SETUP (64) cycles after `spi_cs_n` falls. `spi_cs_n` rises CS_HOLD (96) cycles after the last falling `spi_sck`.
- R5: Every frame begins with an 8-bit opcode, sent MSB first: 8'h03 read, 8'h02 write, 8'h06 write-enable, 8'h05 status read. Read and write frames follow the opcode with an 8-bit address, and a write then sends its 8-bit data byte. The status busy flag is bit 0.
- R6: After reset, the first frame is a status read. Then LOAD_WORDS (4) read frames fetch addresses 0,1,2,3 in that order. Each fetched byte is shown for one cycle on `load_valid`/`load_addr`/`load_data`. After that, `cfg_ready` rises and stays high.
- R7: A write requested before `cfg_ready` rises is neither acknowledged nor started: no write-enable or write frame is sent until the startup load is done. The request is then served.
- R8: An accepted write is sent as these frames in order: write-enable; write with address and data; status reads repeated while bit 0 is 1; a read of the same address. No frame is sent while no request is pending.
- R9: `wr_ack` is asserted only after the read-back frame has ended. `wr_err`=0 when the byte read back equals the byte written.
- R10: When the byte read back differs from the byte written, the write still completes with `wr_ack`=1 and `wr_err`=1.
- R11: `wr_ack` is high for exactly one cycle per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Host write request, held until acknowledged |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 8 | Host write data |
| wr_ack | output | 1 | One-cycle completion of a write |
| wr_err | output | 1 | Read-back mismatch flag, valid with `wr_ack` |
| cfg_ready | output | 1 | Startup load finished, writes accepted |
| load_valid | output | 1 | Startup byte strobe |
| load_addr | output | 8 | Address of the startup byte |
| load_data | output | 8 | Startup byte value |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_cs_n | output | 1 | Active-low EEPROM select |

## Verification
Writes are sent with busy phases of zero, one and two status polls, so a sequencer that skips the poll loop or fails to leave it is caught. Addresses 8'h00 and 8'hFF and data 8'h00 and 8'hFF test the ends of the address and data ranges. The EEPROM model can corrupt a stored byte in the top bit or the bottom bit, which separates a real read-back compare from a hard-wired success. A request raised during the startup load tells a stalled write apart from one that jumps ahead of the configuration reads.

// File: rtl/nvm_spi_pkg.sv
package nvm_spi_pkg;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;

    typedef enum logic [3:0] {
        SQ_BOOT_STAT, SQ_BOOT_LOAD, SQ_READY, SQ_WREN,
        SQ_WRITE, SQ_POLL, SQ_VERIFY, SQ_ACK
    } seq_state_t;

    typedef enum logic [2:0] {
        FR_IDLE, FR_SETUP, FR_HIGH, FR_LOW, FR_HOLD, FR_GAP
    } frame_state_t;
endpackage

// File: rtl/cycle_timer.sv
module cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (load)     cnt <= val;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/spi_frame.sv
module spi_frame
    import nvm_spi_pkg::*;
#(
    parameter int HALF     = 32,
    parameter int CS_SETUP = 64,
    parameter int CS_HOLD  = 96
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  nbits,
    input  logic [23:0] tx,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        cs_n,
    output logic [7:0]  rx,
    output logic        done
);
    localparam int MAXC = (CS_HOLD > CS_SETUP) ? ((CS_HOLD > HALF) ? CS_HOLD : HALF)
                                               : ((CS_SETUP > HALF) ? CS_SETUP : HALF);
    localparam int TW = $clog2(MAXC + 1);
    localparam logic [TW-1:0] HALF_V  = TW'(HALF - 1);
    localparam logic [TW-1:0] SETUP_V = TW'(CS_SETUP - 1);
    localparam logic [TW-1:0] HOLD_V  = TW'(CS_HOLD - 1);

    frame_state_t st, nxt;
    logic          tld, texp;
    logic [TW-1:0] tval;
    logic [23:0]   shreg;
    logic [4:0]    bits_left;

    cycle_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tld), .val(tval), .expired(texp)
    );

    always_comb begin
        nxt  = st;
        tld  = 1'b0;
        tval = '0;
        done = 1'b0;
        unique case (st)
            FR_IDLE:  if (start) begin nxt = FR_SETUP; tld = 1'b1; tval = SETUP_V; end
            FR_SETUP: if (texp)  begin nxt = FR_HIGH;  tld = 1'b1; tval = HALF_V;  end
            FR_HIGH:  if (texp) begin
                tld = 1'b1;
                if (bits_left == 5'd1) begin nxt = FR_HOLD; tval = HOLD_V; end
                else                   begin nxt = FR_LOW;  tval = HALF_V; end
            end
            FR_LOW:   if (texp) begin nxt = FR_HIGH; tld = 1'b1; tval = HALF_V; end
            FR_HOLD:  if (texp) begin nxt = FR_GAP;  tld = 1'b1; tval = HALF_V; end
            FR_GAP:   if (texp) begin nxt = FR_IDLE; done = 1'b1; end
            default:  nxt = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= FR_IDLE;
            sck       <= 1'b0;
            mosi      <= 1'b0;
            cs_n      <= 1'b1;
            rx        <= '0;
            shreg     <= '0;
            bits_left <= '0;
        end else begin
            st <= nxt;
            if (st == FR_IDLE && start) begin
                shreg     <= tx;
                bits_left <= nbits;
                cs_n      <= 1'b0;
            end
            if (nxt == FR_HIGH && st != FR_HIGH) begin
                sck  <= 1'b1;
                mosi <= shreg[23];
            end
            if (st == FR_HIGH && texp) begin
                sck       <= 1'b0;
                rx        <= {rx[6:0], miso};
                shreg     <= {shreg[22:0], 1'b0};
                bits_left <= bits_left - 5'd1;
            end
            if (st == FR_HOLD && texp) cs_n <= 1'b1;
        end
    end
endmodule

// File: rtl/nvm_spi_writethru.sv
module nvm_spi_writethru
    import nvm_spi_pkg::*;
#(
    parameter int HALF       = 32,
    parameter int CS_SETUP   = 64,
    parameter int CS_HOLD    = 96,
    parameter int LOAD_WORDS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       wr_ack,
    output logic       wr_err,
    output logic       cfg_ready,
    output logic       load_valid,
    output logic [7:0] load_addr,
    output logic [7:0] load_data,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);
    localparam int IW = (LOAD_WORDS > 1) ? $clog2(LOAD_WORDS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(LOAD_WORDS - 1);

    seq_state_t    state, nxt;
    logic          launched;
    logic [IW-1:0] load_idx;
    logic [7:0]    lat_a, lat_d;
    logic          err_q;
    logic          fr_start, fr_done, in_frame;
    logic [4:0]    fr_nbits;
    logic [23:0]   fr_tx;
    logic [7:0]    fr_rx;

    spi_frame #(.HALF(HALF), .CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD)) u_frame (
        .clk(clk), .rst_n(rst_n), .start(fr_start), .nbits(fr_nbits), .tx(fr_tx),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .rx(fr_rx), .done(fr_done)
    );

    // next state and outputs
    always_comb begin
        nxt      = state;
        fr_tx    = '0;
        fr_nbits = 5'd8;
        in_frame = 1'b1;
        unique case (state)
            SQ_BOOT_STAT: begin
                fr_tx = {OP_RDSR, 16'h0}; fr_nbits = 5'd16;
                if (fr_done) nxt = SQ_BOOT_LOAD;
            end
            SQ_BOOT_LOAD: begin
                fr_tx = {OP_READ, 8'(load_idx), 8'h0}; fr_nbits = 5'd24;
                if (fr_done && load_idx == LAST_IDX) nxt = SQ_READY;
            end
            SQ_READY: begin
                in_frame = 1'b0;
                if (wr_req) nxt = SQ_WREN;
            end
            SQ_WREN: begin
                fr_tx = {OP_WREN, 16'h0}; fr_nbits = 5'd8;
                if (fr_done) nxt = SQ_WRITE;
            end
            SQ_WRITE: begin
                fr_tx = {OP_WRITE, lat_a, lat_d}; fr_nbits = 5'd24;
                if (fr_done) nxt = SQ_POLL;
            end
            SQ_POLL: begin
                fr_tx = {OP_RDSR, 16'h0}; fr_nbits = 5'd16;
                if (fr_done && !fr_rx[0]) nxt = SQ_VERIFY;
            end
            SQ_VERIFY: begin
                fr_tx = {OP_READ, lat_a, 8'h0}; fr_nbits = 5'd24;
                if (fr_done) nxt = SQ_ACK;
            end
            SQ_ACK: begin
                in_frame = 1'b0;
                nxt = SQ_READY;
            end
            default: begin
                in_frame = 1'b0;
                nxt = SQ_BOOT_STAT;
            end
        endcase
        fr_start   = in_frame && !launched;
        wr_ack     = (state == SQ_ACK);
        wr_err     = err_q;
        cfg_ready  = (state != SQ_BOOT_STAT) && (state != SQ_BOOT_LOAD);
        load_valid = (state == SQ_BOOT_LOAD) && fr_done;
        load_addr  = 8'(load_idx);
        load_data  = fr_rx;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_BOOT_STAT;
            launched <= 1'b0;
            load_idx <= '0;
            lat_a    <= '0;
            lat_d    <= '0;
            err_q    <= 1'b0;
        end else begin
            state <= nxt;
            if (fr_done)       launched <= 1'b0;
            else if (fr_start) launched <= 1'b1;
            if (state == SQ_BOOT_LOAD && fr_done) load_idx <= load_idx + 1'b1;
            if (state == SQ_READY && wr_req) begin
                lat_a <= wr_addr;
                lat_d <= wr_data;
            end
            if (state == SQ_VERIFY && fr_done) err_q <= (fr_rx != lat_d);
        end
    end
endmodule

// File: rtl/nvm_spi_writethru_chk.sv
module nvm_spi_writethru_chk #(
    parameter int CS_SETUP = 64,
    parameter int CS_HOLD  = 96
) (
    input logic clk,
    input logic rst_n,
    input logic spi_sck,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic cfg_ready,
    input logic wr_ack,
    input logic load_valid
);
    logic        cs_d, sck_d;
    logic [15:0] since_cs, since_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d <= 1'b1; sck_d <= 1'b0;
            since_cs <= '0; since_fall <= '0;
        end else begin
            cs_d  <= spi_cs_n;
            sck_d <= spi_sck;
            if (cs_d && !spi_cs_n)        since_cs <= 16'd1;
            else if (since_cs != 16'hFFFF) since_cs <= since_cs + 16'd1;
            if (sck_d && !spi_sck)          since_fall <= 16'd1;
            else if (since_fall != 16'hFFFF) since_fall <= since_fall + 16'd1;
        end
    end

    assert_sck_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);
    assert_mosi_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(spi_sck) |-> $stable(spi_mosi));
    assert_cs_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> since_cs >= 16'(CS_SETUP));
    assert_cs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> since_fall >= 16'(CS_HOLD));
    assert_ready_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> cfg_ready);
    assert_load_before_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> !cfg_ready);
    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);
endmodule

bind nvm_spi_writethru nvm_spi_writethru_chk #(.CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .cfg_ready(cfg_ready), .wr_ack(wr_ack), .load_valid(load_valid)
);

// File: tb/tb_nvm_spi_writethru.sv
module tb_nvm_spi_writethru;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic wr_ack, wr_err, cfg_ready, load_valid;
    logic [7:0] load_addr, load_data;
    logic spi_sck, spi_mosi, spi_cs_n;
    logic spi_miso = 1'b0;

    always #10 clk = ~clk;

    nvm_spi_writethru dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_err(wr_err), .cfg_ready(cfg_ready), .load_valid(load_valid),
        .load_addr(load_addr), .load_data(load_data), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // EEPROM model
    logic [7:0] mem [256];
    logic [7:0] oplog [256];
    int log_n = 0;
    logic [7:0] m_corrupt = '0;
    int m_polls = 0;
    int m_busy = 0, m_bits = 0;
    bit m_wel = 0;
    logic m_cs = 1'b1, m_sck = 1'b0;
    logic [7:0] m_sh = '0, m_op = '0, m_adr = '0, m_dat = '0, m_stat;

    always @(spi_cs_n or spi_sck) begin
        if (spi_cs_n !== m_cs) begin
            if (spi_cs_n === 1'b0) begin
                m_bits = 0; m_op = '0;
            end else if (m_cs === 1'b0 && m_bits >= 8) begin
                if (log_n < 256) oplog[log_n] = m_op;
                log_n++;
                if (m_op == 8'h06) m_wel = 1;
                else if (m_op == 8'h02 && m_bits >= 24 && m_wel) begin
                    mem[m_adr] = m_dat ^ m_corrupt;
                    m_wel = 0;
                    m_busy = m_polls;
                end else if (m_op == 8'h05 && m_busy > 0) m_busy--;
            end
            m_cs = spi_cs_n;
        end
        if (spi_sck !== m_sck) begin
            if (spi_cs_n === 1'b0) begin
                if (spi_sck === 1'b0) begin
                    m_sh = {m_sh[6:0], spi_mosi};
                    m_bits++;
                    if (m_bits == 8)  m_op  = m_sh;
                    if (m_bits == 16) m_adr = m_sh;
                    if (m_bits == 24) m_dat = m_sh;
                end else begin
                    m_stat = {6'b0, m_wel, (m_busy != 0)};
                    if (m_op == 8'h05 && m_bits >= 8 && m_bits < 16)
                        spi_miso = m_stat[15 - m_bits];
                    else if (m_op == 8'h03 && m_bits >= 16 && m_bits < 24)
                        spi_miso = mem[m_adr][23 - m_bits];
                    else spi_miso = 1'b0;
                end
            end
            m_sck = spi_sck;
        end
    end

    // timing and load monitor, sampled mid-cycle
    int hi_min = 9999, hi_max = 0, lo_min = 9999, lo_max = 0;
    int su_min = 9999, su_max = 0, ho_min = 9999, ho_max = 0;
    int c_hi = 0, c_lo = 0, c_cs = 0, c_fall = 0;
    bit p_sck = 0, p_cs = 1, first_rise = 0;
    int ld_n = 0;
    logic [7:0] ld_a [8];
    logic [7:0] ld_d [8];

    always @(negedge clk) begin
        if (rst_n) begin
            c_hi++; c_lo++; c_cs++; c_fall++;
            if (p_cs && !spi_cs_n) begin c_cs = 0; first_rise = 1; end
            if (!p_sck && spi_sck) begin
                if (first_rise) begin
                    if (c_cs < su_min) su_min = c_cs;
                    if (c_cs > su_max) su_max = c_cs;
                    first_rise = 0;
                end else begin
                    if (c_lo < lo_min) lo_min = c_lo;
                    if (c_lo > lo_max) lo_max = c_lo;
                end
                c_hi = 0;
            end
            if (p_sck && !spi_sck) begin
                if (c_hi < hi_min) hi_min = c_hi;
                if (c_hi > hi_max) hi_max = c_hi;
                c_lo = 0; c_fall = 0;
            end
            if (!p_cs && spi_cs_n) begin
                if (c_fall < ho_min) ho_min = c_fall;
                if (c_fall > ho_max) ho_max = c_fall;
            end
            if (load_valid && ld_n < 8) begin
                ld_a[ld_n] = load_addr; ld_d[ld_n] = load_data; ld_n++;
            end
            p_sck = spi_sck; p_cs = spi_cs_n;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_ack(output bit err);
        do @(negedge clk); while (!wr_ack);
        err = wr_err;
        wr_req = 1'b0;
    endtask

    task automatic check_write(input int start, input int polls, input logic [7:0] a,
                               input logic [7:0] d, input logic [7:0] mask, input bit err);
        int n;
        n = log_n - start;
        chk(n == 4 + polls, "R8 frame count", n, 4 + polls);
        chk(oplog[start] == 8'h06, "R8 first frame write-enable", int'(oplog[start]), 'h06);
        chk(oplog[start+1] == 8'h02, "R8 second frame write", int'(oplog[start+1]), 'h02);
        for (int k = 0; k <= polls; k++)
            chk(oplog[start+2+k] == 8'h05, "R8 status poll", int'(oplog[start+2+k]), 'h05);
        chk(oplog[log_n-1] == 8'h03, "R9 read-back before ack", int'(oplog[log_n-1]), 'h03);
        chk(mem[a] == (d ^ mask), "R5 byte stored", int'(mem[a]), int'(d ^ mask));
        if (mask == 0) chk(err == 1'b0, "R9 clean write no error", int'(err), 0);
        else           chk(err == 1'b1, "R10 mismatch error", int'(err), 1);
        @(negedge clk);
        chk(wr_ack == 1'b0, "R11 ack single cycle", int'(wr_ack), 0);
    endtask

    // addr, data, corrupt mask, busy polls
    localparam logic [31:0] VEC [6] = '{
        {8'h10, 8'h5A, 8'h00, 8'd0},
        {8'h11, 8'hA5, 8'h00, 8'd2},
        {8'h00, 8'hFF, 8'h00, 8'd1},
        {8'hFF, 8'h00, 8'h00, 8'd0},
        {8'h20, 8'h3C, 8'h01, 8'd1},
        {8'h21, 8'h81, 8'h80, 8'd0}
    };

    initial begin
        bit e;
        int s;
        int acks;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n idle", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R1 sck idle", int'(spi_sck), 0);
        chk(cfg_ready == 1'b0, "R1 not ready", int'(cfg_ready), 0);
        chk(wr_ack == 1'b0, "R1 no ack", int'(wr_ack), 0);
        rst_n = 1'b1;
        // R7: request raised during startup load
        wr_addr = 8'h40; wr_data = 8'h77; wr_req = 1'b1;
        acks = 0;
        do begin
            @(negedge clk);
            if (wr_ack) acks++;
        end while (!cfg_ready);
        chk(acks == 0, "R7 no ack during load", acks, 0);
        chk(log_n == 1 + 4, "R6 startup frame count", log_n, 5);
        chk(oplog[0] == 8'h05, "R6 first frame status read", int'(oplog[0]), 'h05);
        for (int k = 1; k < 5 && k < log_n; k++)
            chk(oplog[k] == 8'h03, "R7 only reads before ready", int'(oplog[k]), 'h03);
        chk(ld_n == 4, "R6 load strobes", ld_n, 4);
        for (int k = 0; k < 4 && k < ld_n; k++) begin
            chk(ld_a[k] == 8'(k), "R6 load address order", int'(ld_a[k]), k);
            chk(ld_d[k] == mem[k], "R6 load data", int'(ld_d[k]), int'(mem[k]));
        end
        s = log_n;
        wait_ack(e);
        check_write(s, 0, 8'h40, 8'h77, 8'h00, e);

        // table walk
        for (int v = 0; v < 6; v++) begin
            m_polls = int'(VEC[v][7:0]);
            m_corrupt = VEC[v][15:8];
            s = log_n;
            wr_addr = VEC[v][31:24]; wr_data = VEC[v][23:16]; wr_req = 1'b1;
            wait_ack(e);
            check_write(s, int'(VEC[v][7:0]), VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], e);
        end
        m_corrupt = '0; m_polls = 0;

        // R8: idle, no frames without a request
        s = log_n;
        repeat (500) @(negedge clk);
        chk(log_n == s, "R8 idle no frames", log_n - s, 0);
        chk(spi_cs_n == 1'b1, "R2 cs_n high when idle", int'(spi_cs_n), 1);

        // R3 / R4 timing
        chk(hi_min == 32 && hi_max == 32, "R3 sck high cycles", hi_max, 32);
        chk(lo_min == 32 && lo_max == 32, "R3 sck low cycles", lo_max, 32);
        chk(su_min == 64 && su_max == 64, "R4 select setup cycles", su_min, 64);
        chk(ho_min == 96 && ho_max == 96, "R4 select hold cycles", ho_min, 96);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule